// File: doc/BRIEF.md
# Descriptor Chain Walker

This block walks a linked list of buffer descriptors in memory and turns each descriptor into one command for a serial transfer engine. Every descriptor takes 16 bytes and holds four 32-bit words. The control word sits at byte offset 0 and a status word at offset 4. The data buffer address is at offset 8 and the pointer to the next descriptor is at offset 12. Software places the first descriptor's byte address on `chain_base`, holds `ctl_dma_en` high and pulses `ctl_start`. The block then reads the control word, the buffer address and the next pointer over a simple request/acknowledge memory port, and presents a transfer command. When the engine reports completion, the block writes the control word back with its hardware-ownership bit cleared, and then either follows the next pointer or stops.

The block also keeps the interrupt status for the chain. Status bits are sticky and each one is cleared by writing a one to it. The interrupt line is the OR of every bit that is set in the status register, the enable mask and the signal gate mask at the same time. Transfer-engine FIFO events enter as pulses and are captured in the low six status bits. A soft-reset input returns the walker to idle and leaves a fixed pattern in the status register.

Top module: `desc_chain_engine`

## Requirements
- R1: When `ctl_start` is sampled high while idle and `ctl_dma_en` is high, `busy` rises and the first memory read targets `chain_base`. A start pulse with `ctl_dma_en` low is ignored: `busy` stays low and no memory request is made.
- R2: For each descriptor the block reads offsets +0 (control), +8 (buffer address) and +12 (next pointer) from the descriptor's byte address. It never reads offset +4. A pending request keeps its address and direction until `mem_ack`.
- R3: The command decodes the control word as follows. `cmd_len` comes from bits 8:0 and `cmd_rx` from bit 20. `cmd_lanes` is 2 if bit 23 is set, otherwise 1 if bit 22 is set, otherwise 0. `cmd_lsb_first` comes from bit 25, `cmd_dev` from bits 29:28, `cmd_cs_drop` from bit 30, and `cmd_buf_addr` is the word read from offset +8. The command is held stable until `cmd_done`.
- R4: After `cmd_done`, the control word is written back to offset +0 with bit 31 cleared and every other bit unchanged. This happens before the next descriptor is fetched.
- R5: The next-pointer word is followed as the next descriptor's address. After the write-back of a descriptor with bit 19 set, the walk stops and `busy` falls.
- R6: A fetched control word with bit 31 clear, while `ctl_poll_en` is low, stops the walk without issuing a command and sets status bit 11.
- R7: A fetched control word with bit 31 clear, while `ctl_poll_en` is high, makes the block read the same control word again, until bit 31 is found set. No error is raised while it waits.
- R8: If `ctl_dma_en` is low when the current control word is fetched or written back, the walk ends at that point without starting another descriptor.
- R9: Completing a descriptor sets status bit 9 if its control bit 16 is set. It sets status bit 10 if its control bit 17 is set together with bit 18 or bit 19.
- R10: Status bits stay set until a one is written to the same bit of `stat_clr`. A set event in the same cycle as a clear wins.
- R11: `irq` is high exactly when some bit is set in `int_stat`, in `int_en` and in `sig_en` at once.
- R12: A pulse on bit i of `fifo_evt` (i in 0..5) sets status bit i.
- R13: `soft_rst` returns the walker to idle and drops any command or request. It loads the status register with 12'h009 (bits 0 and 3 set).
- R14: After `rst`, the block is idle with no request, no command, zero status and `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Block-level soft reset pulse |
| ctl_dma_en | input | 1 | Walker enable; low aborts at the next boundary |
| ctl_poll_en | input | 1 | Re-read a descriptor not yet owned by hardware |
| ctl_start | input | 1 | Start pulse |
| chain_base | input | ADDR_W | Byte address of the first descriptor |
| fifo_evt | input | 6 | Transfer-engine FIFO event pulses |
| stat_clr | input | 12 | Write-one-to-clear for status bits |
| int_en | input | 12 | Interrupt enable mask |
| sig_en | input | 12 | Interrupt signal gate mask |
| int_stat | output | 12 | Sticky interrupt status |
| irq | output | 1 | Interrupt line |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge (read data valid) |
| mem_rdata | input | 32 | Memory read data |
| cmd_valid | output | 1 | Transfer command present |
| cmd_len | output | 9 | Transfer length |
| cmd_rx | output | 1 | Receive direction |
| cmd_lanes | output | 2 | 0 single, 1 dual, 2 quad |
| cmd_lsb_first | output | 1 | LSB-first bit order |
| cmd_dev | output | 2 | Device select |
| cmd_cs_drop | output | 1 | Release chip select after this transfer |
| cmd_buf_addr | output | ADDR_W | Data buffer address |
| cmd_done | input | 1 | Engine finished the command |
| busy | output | 1 | Walk in progress |

## Verification
The assertions assume a well-behaved memory port and engine. Memory gives one `mem_ack` pulse per request, and only while `mem_req` is high. The engine raises `cmd_done` only while `cmd_valid` is high. `ctl_start` is a single-cycle pulse. The stimulus meets these assumptions with two responders in the bench. Each one waits for a pending request or command and answers after a random delay of a few cycles. Chains are built at distinct 16-byte-aligned slots with random control-word contents, so that the ownership, end-of-list and interrupt-enable bits are the only ones that steer the walk.

// File: rtl/desc_pkg.sv
package desc_pkg;

    localparam int WORD_W  = 32;
    localparam int LEN_W   = 9;
    localparam int STAT_W  = 12;
    localparam int FEVT_W  = 6;

    // control-word bit positions
    localparam int C_DINT  = 16;
    localparam int C_PINT  = 17;
    localparam int C_LIFM  = 18;
    localparam int C_EOL   = 19;
    localparam int C_RX    = 20;
    localparam int C_DUAL  = 22;
    localparam int C_QUAD  = 23;
    localparam int C_LSB   = 25;
    localparam int C_DEV   = 28;
    localparam int C_REL   = 30;
    localparam int C_OWN   = 31;

    // status bit positions
    localparam int ST_TXE   = 0;
    localparam int ST_RXE   = 3;
    localparam int ST_DDONE = 9;
    localparam int ST_PKT   = 10;
    localparam int ST_ERR   = 11;

    localparam logic [STAT_W-1:0] SOFT_MARK = STAT_W'((1 << ST_TXE) | (1 << ST_RXE));

    // descriptor word byte offsets
    localparam logic [3:0] OFS_CTL = 4'd0;
    localparam logic [3:0] OFS_ADR = 4'd8;
    localparam logic [3:0] OFS_NXT = 4'd12;

    typedef enum logic [1:0] {
        LANE_X1 = 2'd0,
        LANE_X2 = 2'd1,
        LANE_X4 = 2'd2
    } lane_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CTL,
        SQ_ADR,
        SQ_NXT,
        SQ_XFER,
        SQ_WB
    } seq_state_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             rx;
        lane_e            lanes;
        logic             lsb_first;
        logic [1:0]       dev;
        logic             cs_drop;
    } xfer_cmd_t;

    typedef struct packed {
        logic desc_done;
        logic pkt_done;
        logic dma_err;
    } chain_evt_t;

    function automatic xfer_cmd_t decode_ctl(input logic [WORD_W-1:0] c);
        xfer_cmd_t x;
        x.len       = c[LEN_W-1:0];
        x.rx        = c[C_RX];
        if (c[C_QUAD])      x.lanes = LANE_X4;
        else if (c[C_DUAL]) x.lanes = LANE_X2;
        else                x.lanes = LANE_X1;
        x.lsb_first = c[C_LSB];
        x.dev       = c[C_DEV +: 2];
        x.cs_drop   = c[C_REL];
        return x;
    endfunction

    function automatic logic [3:0] word_offset(input seq_state_e s);
        case (s)
            SQ_ADR:  return OFS_ADR;
            SQ_NXT:  return OFS_NXT;
            default: return OFS_CTL;
        endcase
    endfunction

endpackage

// File: rtl/desc_seq.sv
module desc_seq
    import desc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              dma_en,
    input  logic              poll_en,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              cmd_valid,
    output xfer_cmd_t         cmd,
    output logic [ADDR_W-1:0] cmd_buf_addr,
    input  logic              cmd_done,
    output chain_evt_t        evt,
    output logic              busy
);

    seq_state_e        state;
    logic [ADDR_W-1:0] ptr;
    logic [WORD_W-1:0] ctl_q;
    logic [ADDR_W-1:0] adr_q;
    logic [ADDR_W-1:0] nxt_q;

    logic ctl_ack, wb_ack, not_owned;

    assign ctl_ack   = (state == SQ_CTL) && mem_ack;
    assign wb_ack    = (state == SQ_WB) && mem_ack;
    assign not_owned = !mem_rdata[C_OWN];

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            state <= SQ_IDLE;
            ptr   <= '0;
            ctl_q <= '0;
            adr_q <= '0;
            nxt_q <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start && dma_en) begin
                        ptr   <= base;
                        state <= SQ_CTL;
                    end
                end
                SQ_CTL: begin
                    if (mem_ack) begin
                        ctl_q <= mem_rdata;
                        if (!dma_en)
                            state <= SQ_IDLE;
                        else if (!not_owned)
                            state <= SQ_ADR;
                        else if (!poll_en)
                            state <= SQ_IDLE;
                    end
                end
                SQ_ADR: begin
                    if (mem_ack) begin
                        adr_q <= mem_rdata[ADDR_W-1:0];
                        state <= SQ_NXT;
                    end
                end
                SQ_NXT: begin
                    if (mem_ack) begin
                        nxt_q <= mem_rdata[ADDR_W-1:0];
                        state <= SQ_XFER;
                    end
                end
                SQ_XFER: begin
                    if (cmd_done)
                        state <= SQ_WB;
                end
                SQ_WB: begin
                    if (mem_ack) begin
                        if (ctl_q[C_EOL] || !dma_en) begin
                            state <= SQ_IDLE;
                        end else begin
                            ptr   <= nxt_q;
                            state <= SQ_CTL;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req = (state == SQ_CTL) || (state == SQ_ADR) ||
                  (state == SQ_NXT) || (state == SQ_WB);
        mem_we  = (state == SQ_WB);
        mem_addr = ptr + {{(ADDR_W-4){1'b0}}, word_offset(state)};
        mem_wdata = ctl_q;
        mem_wdata[C_OWN] = 1'b0;
    end

    assign cmd_valid    = (state == SQ_XFER);
    assign cmd          = decode_ctl(ctl_q);
    assign cmd_buf_addr = adr_q;
    assign busy         = (state != SQ_IDLE);

    assign evt.desc_done = wb_ack && ctl_q[C_DINT];
    assign evt.pkt_done  = wb_ack && ctl_q[C_PINT] && (ctl_q[C_LIFM] || ctl_q[C_EOL]);
    assign evt.dma_err   = ctl_ack && dma_en && not_owned && !poll_en;

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(start && dma_en)) |=> !busy);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R3
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd) && $stable(cmd_buf_addr)));

    // R5
    eol_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_ack && ctl_q[C_EOL]) |=> !busy);

    // R6
    own_err_chk: assert property (@(posedge clk) disable iff (rst)
        evt.dma_err |=> (!busy && !cmd_valid));

    // R7
    poll_again_chk: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (ctl_ack && dma_en && poll_en && not_owned) |=> (mem_req && !mem_we && $stable(mem_addr)));

    // R8
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_ack && !dma_en) |=> !busy);

endmodule

// File: rtl/desc_irq.sv
module desc_irq
    import desc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  chain_evt_t        evt,
    input  logic [FEVT_W-1:0] fifo_evt,
    input  logic [STAT_W-1:0] stat_clr,
    input  logic [STAT_W-1:0] int_en,
    input  logic [STAT_W-1:0] sig_en,
    output logic [STAT_W-1:0] stat,
    output logic              irq
);

    logic [STAT_W-1:0] set_vec;

    for (genvar g = 0; g < STAT_W; g++) begin : g_set
        if (g < FEVT_W) begin : g_fifo
            assign set_vec[g] = fifo_evt[g];
        end else if (g == ST_DDONE) begin : g_ddone
            assign set_vec[g] = evt.desc_done;
        end else if (g == ST_PKT) begin : g_pkt
            assign set_vec[g] = evt.pkt_done;
        end else if (g == ST_ERR) begin : g_err
            assign set_vec[g] = evt.dma_err;
        end else begin : g_none
            assign set_vec[g] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            stat <= '0;
        else if (soft_rst)
            stat <= SOFT_MARK;
        else
            stat <= (stat & ~stat_clr) | set_vec;
    end

    assign irq = |(stat & int_en & sig_en);

    // R10
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!soft_rst && stat_clr == '0) |=> ((stat & $past(stat)) == $past(stat)));

    // R12
    fifo_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!soft_rst && fifo_evt != '0) |=>
            ((stat[FEVT_W-1:0] & $past(fifo_evt)) == $past(fifo_evt)));

    // R13
    soft_mark_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (stat == SOFT_MARK));

endmodule

// File: rtl/desc_chain_engine.sv
module desc_chain_engine
    import desc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              ctl_dma_en,
    input  logic              ctl_poll_en,
    input  logic              ctl_start,
    input  logic [ADDR_W-1:0] chain_base,
    input  logic [FEVT_W-1:0] fifo_evt,
    input  logic [STAT_W-1:0] stat_clr,
    input  logic [STAT_W-1:0] int_en,
    input  logic [STAT_W-1:0] sig_en,
    output logic [STAT_W-1:0] int_stat,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              cmd_valid,
    output logic [LEN_W-1:0]  cmd_len,
    output logic              cmd_rx,
    output logic [1:0]        cmd_lanes,
    output logic              cmd_lsb_first,
    output logic [1:0]        cmd_dev,
    output logic              cmd_cs_drop,
    output logic [ADDR_W-1:0] cmd_buf_addr,
    input  logic              cmd_done,
    output logic              busy
);

    xfer_cmd_t  cmd_s;
    chain_evt_t evt_s;

    desc_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .soft_rst     (soft_rst),
        .dma_en       (ctl_dma_en),
        .poll_en      (ctl_poll_en),
        .start        (ctl_start),
        .base         (chain_base),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .cmd_valid    (cmd_valid),
        .cmd          (cmd_s),
        .cmd_buf_addr (cmd_buf_addr),
        .cmd_done     (cmd_done),
        .evt          (evt_s),
        .busy         (busy)
    );

    desc_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .evt      (evt_s),
        .fifo_evt (fifo_evt),
        .stat_clr (stat_clr),
        .int_en   (int_en),
        .sig_en   (sig_en),
        .stat     (int_stat),
        .irq      (irq)
    );

    assign cmd_len       = cmd_s.len;
    assign cmd_rx        = cmd_s.rx;
    assign cmd_lanes     = cmd_s.lanes;
    assign cmd_lsb_first = cmd_s.lsb_first;
    assign cmd_dev       = cmd_s.dev;
    assign cmd_cs_drop   = cmd_s.cs_drop;

    // R11
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (int_stat != '0));

    // R14
    quiet_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !cmd_valid));

endmodule

// File: tb/desc_chain_engine_bench.sv
module desc_chain_engine_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        dma_en = 1'b0;
    logic        poll_en = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base = '0;
    logic [5:0]  fifo_evt = '0;
    logic [11:0] stat_clr = '0;
    logic [11:0] int_en = '0;
    logic [11:0] sig_en = '0;
    logic [11:0] int_stat;
    logic        irq;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        cmd_valid;
    logic [8:0]  cmd_len;
    logic        cmd_rx;
    logic [1:0]  cmd_lanes;
    logic        cmd_lsb_first;
    logic [1:0]  cmd_dev;
    logic        cmd_cs_drop;
    logic [31:0] cmd_buf_addr;
    logic        cmd_done = 1'b0;
    logic        busy;

    desc_chain_engine u_desc_chain_engine (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .ctl_dma_en(dma_en), .ctl_poll_en(poll_en), .ctl_start(start),
        .chain_base(base), .fifo_evt(fifo_evt), .stat_clr(stat_clr),
        .int_en(int_en), .sig_en(sig_en), .int_stat(int_stat), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .cmd_valid(cmd_valid), .cmd_len(cmd_len), .cmd_rx(cmd_rx),
        .cmd_lanes(cmd_lanes), .cmd_lsb_first(cmd_lsb_first),
        .cmd_dev(cmd_dev), .cmd_cs_drop(cmd_cs_drop),
        .cmd_buf_addr(cmd_buf_addr), .cmd_done(cmd_done), .busy(busy)
    );

    initial forever #4 clk = ~clk;

    logic [31:0] mem [0:63];
    logic [31:0] exp_ctl [0:7];
    logic [31:0] exp_adr [0:7];
    int          slot_of [0:7];
    int          exp_n = 0;
    int          n_cmd = 0;
    int          n_rd = 0;
    int          n_rd_stat = 0;
    logic [31:0] first_rd = '0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_lanes(input logic [31:0] c);
        if (c[23]) return 2'd2;
        if (c[22]) return 2'd1;
        return 2'd0;
    endfunction

    task automatic check_cmd();
        logic [31:0] c;
        if (n_cmd >= exp_n) begin
            chk_eq("R8 unexpected command count", n_cmd + 1, exp_n);
        end else begin
            c = exp_ctl[n_cmd];
            chk_eq("R3 length", cmd_len, c[8:0]);
            chk_eq("R3 receive", cmd_rx, c[20]);
            chk_eq("R3 lanes", cmd_lanes, exp_lanes(c));
            chk_eq("R3 lsb first", cmd_lsb_first, c[25]);
            chk_eq("R3 device", cmd_dev, c[29:28]);
            chk_eq("R3 cs release", cmd_cs_drop, c[30]);
            chk_eq("R3 buffer address", cmd_buf_addr, exp_adr[n_cmd]);
        end
        n_cmd++;
    endtask

    // memory responder
    initial begin
        int wcnt;
        wcnt = 0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req) begin
                if (wcnt == 0) begin
                    if (mem_we) begin
                        mem[mem_addr[7:2]] = mem_wdata;
                    end else begin
                        mem_rdata = mem[mem_addr[7:2]];
                        n_rd++;
                        if (n_rd == 1) first_rd = mem_addr;
                        if (mem_addr[3:2] == 2'd1) n_rd_stat++;
                    end
                    mem_ack = 1'b1;
                    wcnt = $urandom_range(0, 3);
                end else begin
                    wcnt--;
                end
            end
        end
    end

    // transfer engine responder
    initial begin
        int dcnt;
        dcnt = 0;
        forever begin
            @(negedge clk);
            cmd_done = 1'b0;
            if (cmd_valid) begin
                if (dcnt == 0) begin
                    check_cmd();
                    cmd_done = 1'b1;
                    dcnt = $urandom_range(0, 4);
                end else begin
                    dcnt--;
                end
            end
        end
    end

    task automatic build_chain(input int n, input bit owned_first);
        int s;
        logic [31:0] c;
        s = $urandom_range(0, 15);
        for (int i = 0; i < n; i++) begin
            int sl;
            sl = (s + 3 * i) % 16;
            slot_of[i] = sl;
            c = $urandom;
            c[31] = 1'b1;
            c[19] = (i == n - 1);
            if (i == 0 && !owned_first) c[31] = 1'b0;
            exp_ctl[i] = c;
            exp_adr[i] = $urandom;
            mem[sl * 4]     = c;
            mem[sl * 4 + 1] = $urandom;
            mem[sl * 4 + 2] = exp_adr[i];
            mem[sl * 4 + 3] = (i == n - 1) ? 32'h0 : 32'(((s + 3 * (i + 1)) % 16) * 16);
        end
        exp_n = n;
        base  = 32'(s * 16);
        n_cmd = 0;
        n_rd  = 0;
        n_rd_stat = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 3000; k++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic clear_all();
        @(negedge clk);
        stat_clr = 12'hfff;
        @(negedge clk);
        stat_clr = 12'h000;
    endtask

    task automatic run_random_chain(input int n);
        bit ed, ep;
        build_chain(n, 1'b1);
        dma_en = 1'b1;
        int_en = 12'hfff;
        sig_en = 12'hfff;
        pulse_start();
        wait_idle();
        repeat (2) @(negedge clk);
        chk_eq("R5 walk finished", busy, 1'b0);
        chk_eq("R5 commands in chain", n_cmd, n);
        chk_eq("R1 first read at base", first_rd, base);
        chk_eq("R2 status word never read", n_rd_stat, 0);
        chk_eq("R2 reads per descriptor", n_rd, 3 * n);
        ed = 1'b0;
        ep = 1'b0;
        for (int i = 0; i < n; i++) begin
            chk_eq("R4 write-back", mem[slot_of[i] * 4], exp_ctl[i] & 32'h7fff_ffff);
            ed |= exp_ctl[i][16];
            ep |= exp_ctl[i][17] & (exp_ctl[i][18] | exp_ctl[i][19]);
        end
        chk_eq("R9 descriptor done status", int_stat[9], ed);
        chk_eq("R9 packet complete status", int_stat[10], ep);
        chk_eq("R11 irq follows gated status", irq, (ed | ep));
        clear_all();
        chk_eq("R10 write-one clear", int_stat, 12'h000);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R14 reset state
        chk_eq("R14 busy after reset", busy, 1'b0);
        chk_eq("R14 no request after reset", mem_req, 1'b0);
        chk_eq("R14 no command after reset", cmd_valid, 1'b0);
        chk_eq("R14 status after reset", int_stat, 12'h000);
        chk_eq("R14 irq after reset", irq, 1'b0);

        // R1 start ignored without enable
        n_rd = 0;
        dma_en = 1'b0;
        pulse_start();
        repeat (5) @(negedge clk);
        chk_eq("R1 start without enable busy", busy, 1'b0);
        chk_eq("R1 start without enable reads", n_rd, 0);

        // directed corner: one-descriptor chain
        run_random_chain(1);

        // random chains
        for (int t = 0; t < 12; t++) run_random_chain($urandom_range(1, 5));

        // R6 ownership error
        build_chain(2, 1'b0);
        dma_en = 1'b1;
        poll_en = 1'b0;
        int_en = 12'h800;
        sig_en = 12'h000;
        pulse_start();
        wait_idle();
        repeat (2) @(negedge clk);
        chk_eq("R6 no command for unowned", n_cmd, 0);
        chk_eq("R6 error status bit 11", int_stat, 12'h800);
        chk_eq("R6 control word untouched", mem[slot_of[0] * 4], exp_ctl[0]);
        chk_eq("R11 irq gated off by signal mask", irq, 1'b0);
        @(negedge clk);
        sig_en = 12'h800;
        @(negedge clk);
        chk_eq("R11 irq with all three set", irq, 1'b1);
        int_en = 12'h000;
        @(negedge clk);
        chk_eq("R11 irq gated off by enable mask", irq, 1'b0);
        clear_all();

        // R7 polling an unowned descriptor
        build_chain(1, 1'b0);
        poll_en = 1'b1;
        pulse_start();
        repeat (30) @(negedge clk);
        chk_eq("R7 still busy while polling", busy, 1'b1);
        chk_eq("R7 no command while polling", n_cmd, 0);
        chk_eq("R7 repeated reads", (n_rd >= 3), 1'b1);
        chk_eq("R7 polling reads at base", first_rd, base);
        chk_eq("R7 no error while polling", int_stat[11], 1'b0);
        exp_ctl[0][31] = 1'b1;
        mem[slot_of[0] * 4] = exp_ctl[0];
        wait_idle();
        repeat (2) @(negedge clk);
        chk_eq("R7 command once owned", n_cmd, 1);
        chk_eq("R7 write-back after poll", mem[slot_of[0] * 4], exp_ctl[0] & 32'h7fff_ffff);
        poll_en = 1'b0;
        clear_all();

        // R8 abort at boundary
        build_chain(3, 1'b1);
        dma_en = 1'b1;
        pulse_start();
        for (int k = 0; k < 500; k++) begin
            if (n_cmd >= 1) break;
            @(negedge clk);
        end
        dma_en = 1'b0;
        wait_idle();
        repeat (4) @(negedge clk);
        chk_eq("R8 single command before abort", n_cmd, 1);
        chk_eq("R8 first descriptor written back", mem[slot_of[0] * 4], exp_ctl[0] & 32'h7fff_ffff);
        chk_eq("R8 second descriptor untouched", mem[slot_of[1] * 4], exp_ctl[1]);
        dma_en = 1'b1;
        clear_all();

        // R12 and R10 sticky FIFO events
        @(negedge clk);
        fifo_evt = 6'b000100;
        @(negedge clk);
        fifo_evt = 6'b000000;
        repeat (3) @(negedge clk);
        chk_eq("R12 fifo event captured", int_stat, 12'h004);
        stat_clr = 12'h004;
        fifo_evt = 6'b000100;
        @(negedge clk);
        stat_clr = 12'h000;
        fifo_evt = 6'b000000;
        chk_eq("R10 set wins over clear", int_stat, 12'h004);
        fifo_evt = 6'b100001;
        @(negedge clk);
        fifo_evt = 6'b000000;
        stat_clr = 12'h005;
        @(negedge clk);
        stat_clr = 12'h000;
        chk_eq("R10 clear only the written bits", int_stat, 12'h020);
        clear_all();

        // R13 soft reset in the middle of a chain
        build_chain(4, 1'b1);
        pulse_start();
        repeat (6) @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        chk_eq("R13 idle after soft reset", busy, 1'b0);
        chk_eq("R13 status after soft reset", int_stat, 12'h009);
        chk_eq("R13 no command after soft reset", cmd_valid, 1'b0);
        chk_eq("R13 no request after soft reset", mem_req, 1'b0);
        clear_all();

        // walker usable again after soft reset
        run_random_chain(3);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule